// File: doc/BRIEF.md
# Conversion Result Window Comparator

This block watches a stream of conversion results and decides, for each result, whether it satisfies a programmable window condition built from a lower and an upper threshold. A result is presented together with a one-cycle valid strobe. The comparison takes one clock. A match sets a sticky flag and, if event output is enabled, produces a one-cycle event pulse.

The resolution setting selects how many low bits of the result and of both thresholds take part in the comparison. The mode bit selects unsigned (single-ended) or two's-complement (differential) interpretation. In differential mode the top bit of the active resolution is the sign, so both thresholds are truncated to that width and sign-extended from it. Software clears the flag by pulsing a clear input high.

Top module: `result_window_cmp`

## Requirements
- R1: After reset, `win_flag` and `win_evt` are both 0.
- R2: A window mode of 0 never produces a match. Window modes 5, 6 and 7 behave like 0.
- R3: Window mode 1 matches when the result is strictly greater than the lower threshold.
- R4: Window mode 2 matches when the result is strictly less than the upper threshold.
- R5: Window mode 3 matches when lower <= result <= upper, with both bounds inclusive.
- R6: Window mode 4 matches when the result is less than the lower threshold or greater than the upper threshold.
- R7: When `diff_mode` is 0, the result and both thresholds are compared as unsigned numbers.
- R8: When `diff_mode` is 1, the result and both thresholds are compared as two's-complement numbers. The sign is taken from the top bit of the active resolution: bit 7 for resolution code 0 (8 bits), bit 9 for code 1 (10 bits), and bit 11 for codes 2 and 3 (12 bits).
- R9: Bits of the result and of the thresholds above the active resolution have no effect on the outcome.
- R10: A match is evaluated only in a cycle where `res_valid` is 1. The resulting flag and event appear one clock after that strobe.
- R11: `win_evt` pulses for exactly one cycle on a match, and only when `evt_en` was 1 in the strobe cycle. `win_flag` is set on every match, whatever the value of `evt_en`.
- R12: `win_flag` stays set until a cycle with `flag_clr` = 1 clears it. If a clear and a match occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | Result strobe, one cycle per result |
| res_data | input | DATA_W | Right-adjusted conversion result |
| res_sel | input | 2 | Resolution code: 0 = 8 bits, 1 = 10 bits, 2 or 3 = 12 bits |
| diff_mode | input | 1 | 1 selects signed comparison |
| win_mode | input | 3 | Window condition select (see R2 to R6) |
| thr_lo | input | DATA_W | Lower threshold |
| thr_hi | input | DATA_W | Upper threshold |
| evt_en | input | 1 | Enables the event pulse |
| flag_clr | input | 1 | Write-one-to-clear for the flag |
| win_flag | output | 1 | Sticky match flag |
| win_evt | output | 1 | One-cycle match event |

## Verification
The block's only state is the sticky flag and the event register. A wrong normalisation or a wrong comparison therefore shows as a wrong flag or event exactly one clock after the offending strobe. A lost or spurious flag keeps its wrong value until the next clear or match. The bench models the sign and truncation rules with plain integers and compares both outputs every cycle. It runs directed cases at the resolution boundaries and sign edges, then a long stretch of mixed stimulus, so any divergence is reported in the cycle where it appears.

// File: rtl/result_window_cmp.sv
module result_window_cmp #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [1:0]        res_sel,
  input  logic              diff_mode,
  input  logic [2:0]        win_mode,
  input  logic [DATA_W-1:0] thr_lo,
  input  logic [DATA_W-1:0] thr_hi,
  input  logic              evt_en,
  input  logic              flag_clr,
  output logic              win_flag,
  output logic              win_evt
);
  localparam int MAX_RES = 12;
  localparam int CW      = MAX_RES + 1;

  function automatic logic signed [CW-1:0] norm(input logic [DATA_W-1:0] v,
                                                 input logic [1:0] sel,
                                                 input logic sgn);
    logic [CW-1:0] r;
    case (sel)
      2'd0:    r = {{(CW-8){sgn & v[7]}}, v[7:0]};
      2'd1:    r = {{(CW-10){sgn & v[9]}}, v[9:0]};
      default: r = {{(CW-12){sgn & v[11]}}, v[11:0]};
    endcase
    return signed'(r);
  endfunction

  logic signed [CW-1:0] r_n, lo_n, hi_n;
  logic gt_lo, lt_hi, ge_lo, le_hi, hit;

  assign r_n  = norm(res_data, res_sel, diff_mode);
  assign lo_n = norm(thr_lo, res_sel, diff_mode);
  assign hi_n = norm(thr_hi, res_sel, diff_mode);

  assign gt_lo = r_n >  lo_n;
  assign ge_lo = r_n >= lo_n;
  assign lt_hi = r_n <  hi_n;
  assign le_hi = r_n <= hi_n;

  always_comb begin
    case (win_mode)
      3'd1:    hit = gt_lo;
      3'd2:    hit = lt_hi;
      3'd3:    hit = ge_lo & le_hi;
      3'd4:    hit = ~(ge_lo & le_hi);
      default: hit = 1'b0;
    endcase
  end

  wire match = res_valid & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_flag <= 1'b0;
      win_evt  <= 1'b0;
    end else begin
      win_evt <= match & evt_en;
      if (match)         win_flag <= 1'b1;
      else if (flag_clr) win_flag <= 1'b0;
    end
  end
endmodule

module result_window_cmp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       res_valid,
  input logic [2:0] win_mode,
  input logic       evt_en,
  input logic       flag_clr,
  input logic       win_flag,
  input logic       win_evt
);
  assert_evt_after_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    win_evt |-> $past(res_valid));
  assert_evt_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    win_evt |-> $past(evt_en));
  assert_evt_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    win_evt |-> win_flag);
  assert_evt_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (win_evt && !res_valid) |=> !win_evt);
  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (win_mode == 3'd0 || win_mode > 3'd4)) |=> !win_evt);
  assert_clear_works_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !res_valid) |=> !win_flag);
  assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (win_flag && !flag_clr) |=> win_flag);
endmodule

bind result_window_cmp result_window_cmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .win_mode(win_mode),
  .evt_en(evt_en), .flag_clr(flag_clr), .win_flag(win_flag), .win_evt(win_evt)
);

// File: tb/result_window_cmp_bench.sv
module result_window_cmp_bench;
  localparam int DW = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic res_valid = 0;
  logic [DW-1:0] res_data = '0, thr_lo = '0, thr_hi = '0;
  logic [1:0] res_sel = '0;
  logic diff_mode = 0, evt_en = 0, flag_clr = 0;
  logic [2:0] win_mode = '0;
  logic win_flag, win_evt;

  always #5 clk = ~clk;

  result_window_cmp #(.DATA_W(DW)) u_result_window_cmp (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .res_sel(res_sel), .diff_mode(diff_mode), .win_mode(win_mode),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .evt_en(evt_en), .flag_clr(flag_clr),
    .win_flag(win_flag), .win_evt(win_evt));

  int vectors = 0, errs = 0;
  bit done = 0;
  bit m_flag = 0;

  function automatic int val(int x, int sel, bit d);
    int w = (sel == 0) ? 8 : (sel == 1) ? 10 : 12;
    int m = x & ((1 << w) - 1);
    if (d && m >= (1 << (w - 1))) m -= (1 << w);
    return m;
  endfunction

  function automatic bit ref_hit(int mode, int r, int lo, int hi);
    case (mode)
      1: return r > lo;
      2: return r < hi;
      3: return (r >= lo) && (r <= hi);
      4: return (r < lo) || (r > hi);
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, bit ef, bit ee);
    vectors++;
    if (win_flag !== ef || win_evt !== ee) begin
      errs++;
      $display("FAIL %s: flag=%0b evt=%0b expected flag=%0b evt=%0b",
               tag, win_flag, win_evt, ef, ee);
    end
  endtask

  task automatic step(string tag, bit v, int d, int sel, bit df, int mode,
                      int lo, int hi, bit en, bit clr);
    bit h, ee;
    res_valid = v; res_data = d[DW-1:0]; res_sel = sel[1:0]; diff_mode = df;
    win_mode = mode[2:0]; thr_lo = lo[DW-1:0]; thr_hi = hi[DW-1:0];
    evt_en = en; flag_clr = clr;
    h = v && ref_hit(mode, val(d, sel, df), val(lo, sel, df), val(hi, sel, df));
    ee = h && en;
    if (h) m_flag = 1; else if (clr) m_flag = 0;
    @(posedge clk); @(negedge clk);
    check(tag, m_flag, ee);
  endtask

  task automatic clr1();
    step("R12", 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 0, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", 0, 0);

    // R2: disabled modes never match
    step("R2", 1, 5, 2, 0, 0, 0, 100, 1, 0);
    step("R2", 1, 5, 2, 0, 5, 0, 100, 1, 0);
    step("R2", 1, 5, 2, 0, 7, 0, 100, 1, 0);
    // R3: strict above lower
    step("R3", 1, 100, 2, 0, 1, 100, 0, 1, 0);
    step("R3", 1, 101, 2, 0, 1, 100, 0, 1, 0);
    clr1();
    // R4: strict below upper
    step("R4", 1, 200, 2, 0, 2, 0, 200, 1, 0);
    step("R4", 1, 199, 2, 0, 2, 0, 200, 1, 0);
    clr1();
    // R5: inclusive bounds
    step("R5", 1, 10, 2, 0, 3, 10, 20, 1, 0);
    clr1();
    step("R5", 1, 20, 2, 0, 3, 10, 20, 1, 0);
    clr1();
    step("R5", 1, 21, 2, 0, 3, 10, 20, 1, 0);
    // R6: outside
    step("R6", 1, 9, 2, 0, 4, 10, 20, 1, 0);
    clr1();
    step("R6", 1, 15, 2, 0, 4, 10, 20, 1, 0);
    // R7 vs R8: 0x80 above 0x7F unsigned, below it signed in 8-bit mode
    step("R7", 1, 'h80, 0, 0, 1, 'h7F, 0, 1, 0);
    clr1();
    step("R8", 1, 'h80, 0, 1, 1, 'h7F, 0, 1, 0);
    step("R8", 1, 'h200, 1, 1, 2, 0, 'h1FF, 1, 0);
    clr1();
    step("R8", 1, 'h800, 3, 1, 2, 0, 1, 1, 0);
    clr1();
    // R9: high bits ignored; threshold 0x1FF in 8-bit diff is -1
    step("R9", 1, 'hFF00, 0, 0, 1, 'h0F00, 0, 1, 0);
    step("R9", 1, 'h0000, 0, 1, 1, 'h01FF, 0, 1, 0);
    clr1();
    // R10: no strobe, no match
    step("R10", 0, 50, 2, 0, 1, 0, 0, 1, 0);
    // R11: flag without event
    step("R11", 1, 50, 2, 0, 1, 0, 0, 0, 0);
    step("R11", 0, 0, 2, 0, 1, 0, 0, 1, 0);
    // R12: match wins over clear, then clear works
    step("R12", 1, 50, 2, 0, 1, 0, 0, 1, 1);
    clr1();
    step("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      int mode = $urandom_range(0, 7);
      int sel  = $urandom_range(0, 3);
      bit df   = $urandom_range(0, 1);
      step(df ? "R8" : "R7", $urandom_range(0, 3) != 0, $urandom_range(0, 65535),
           sel, df, mode, $urandom_range(0, 65535), $urandom_range(0, 65535),
           $urandom_range(0, 1), $urandom_range(0, 4) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule